// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block keeps a small, fully associative set of page translations. Each slot holds a virtual page tag, a physical page number, an address-space number, a global flag, one read-enable and one write-enable bit for each privilege mode, and two trap flags: one for reads and one for writes. A lookup compares the presented virtual page number and address-space number against every slot in the same cycle. It returns the translation and its permission fields from the matching slot with the lowest index.

New translations enter through an insert port. The insert always overwrites the slot chosen by a round-robin victim pointer, and then the pointer moves on. Three invalidation commands are provided. The first clears everything. The second drops every translation that is not global. The third drops the translations that match one page under the lookup rule. A side port shows the slot at the victim pointer, so that the surrounding logic can read or save the entry. The pointer can be stepped from this port without writing anything.

Top module: `asn_tlb`

## Requirements
- R1: After reset no slot is valid, the victim pointer is 0, every lookup misses and `vic_valid` is 0.
- R2: A lookup hits only on a valid slot whose tag equals `lk_vpn` and whose global flag is set or whose stored address-space number equals `lk_asn`. On a hit, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_trap_rd` and `lk_trap_wr` show that slot's fields. Bit m of each enable mask belongs to privilege mode m.
- R3: A non-global slot with the right tag misses when the address-space numbers differ.
- R4: An accepted insert writes the slot at the victim pointer, replacing any valid translation there. The insert takes its tag from `ins_vpn` and sets the slot valid. The pointer then advances, wrapping from NUM_ENTRIES-1 to 0.
- R5: When several slots hit, `lk_idx` and the returned fields come from the lowest-numbered hitting slot.
- R6: `fl_all` clears every valid bit and sets the victim pointer to 0 at the next edge.
- R7: `fl_proc` invalidates every non-global slot and keeps every global slot.
- R8: `fl_page` invalidates every slot that would hit a lookup of (`fl_vpn`, `fl_asn`), and no other slot.
- R9: The `vic_*` outputs show the slot at the victim pointer. `vic_adv` advances the pointer without changing any slot.
- R10: An insert in the same cycle as any flush is dropped. It writes nothing, and the pointer moves only if `vic_adv` or `fl_all` moves it.
- R11: The lookup is combinational on the registered contents. An insert becomes visible to lookups after the clock edge that accepts it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the hitting slot |
| lk_ppn | output | PPN_W | Physical page number of the hit |
| lk_rd_en | output | MODE_N | Per-mode read enables of the hit |
| lk_wr_en | output | MODE_N | Per-mode write enables of the hit |
| lk_trap_rd | output | 1 | Trap-on-read flag of the hit |
| lk_trap_wr | output | 1 | Trap-on-write flag of the hit |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Tag to insert |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_asn | input | ASN_W | Address-space number to insert |
| ins_global | input | 1 | Global flag to insert |
| ins_rd_en | input | MODE_N | Per-mode read enables to insert |
| ins_wr_en | input | MODE_N | Per-mode write enables to insert |
| ins_trap_rd | input | 1 | Trap-on-read flag to insert |
| ins_trap_wr | input | 1 | Trap-on-write flag to insert |
| fl_all | input | 1 | Invalidate all slots, reset pointer |
| fl_proc | input | 1 | Invalidate non-global slots |
| fl_page | input | 1 | Invalidate slots matching fl_vpn/fl_asn |
| fl_vpn | input | VPN_W | Page for fl_page |
| fl_asn | input | ASN_W | Address-space number for fl_page |
| vic_adv | input | 1 | Step the victim pointer |
| vic_ptr | output | IDX_W | Victim pointer |
| vic_valid | output | 1 | Valid bit of the victim slot |
| vic_vpn | output | VPN_W | Tag of the victim slot |
| vic_ppn | output | PPN_W | Physical page of the victim slot |
| vic_asn | output | ASN_W | Address-space number of the victim slot |
| vic_global | output | 1 | Global flag of the victim slot |

## Verification
The bench builds the block with NUM_ENTRIES set to 4. With that depth, four inserts fill the buffer and the fifth replaces slot 0, so the pointer wrap and the overwrite of a live translation both occur early in the run. The package widths stay at their defaults. The bench places duplicate tags in slots 0 and 3 and a second address-space number in slot 2, so the lowest-index rule and the address-space filter are both tested within those four slots.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    parameter int VPN_W  = 30;
    parameter int PPN_W  = 28;
    parameter int ASN_W  = 8;
    parameter int MODE_N = 4;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [ASN_W-1:0]  asn;
        logic              glob;
        logic [MODE_N-1:0] rd_en;
        logic [MODE_N-1:0] wr_en;
        logic              trap_rd;
        logic              trap_wr;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_cam_match.sv
module tlb_cam_match
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 48
) (
    input  tlb_entry_t [NUM_ENTRIES-1:0] ent_i,
    input  logic [NUM_ENTRIES-1:0]       valid_i,
    input  logic [VPN_W-1:0]             vpn_i,
    input  logic [ASN_W-1:0]             asn_i,
    output logic [NUM_ENTRIES-1:0]       hit_o
);
    // One comparator per slot: tag equal, and global or same address space.
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        logic tag_eq;
        logic asn_ok;
        assign tag_eq   = (ent_i[g].vpn == vpn_i);
        assign asn_ok   = ent_i[g].glob || (ent_i[g].asn == asn_i);
        assign hit_o[g] = valid_i[g] && tag_eq && asn_ok;
    end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
    parameter int NUM_ENTRIES = 48,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [NUM_ENTRIES-1:0] req_i,
    output logic                   found_o,
    output logic [IDX_W-1:0]       idx_o
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 48,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [MODE_N-1:0] lk_rd_en,
    output logic [MODE_N-1:0] lk_wr_en,
    output logic              lk_trap_rd,
    output logic              lk_trap_wr,
    input  logic              ins_valid,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic              ins_global,
    input  logic [MODE_N-1:0] ins_rd_en,
    input  logic [MODE_N-1:0] ins_wr_en,
    input  logic              ins_trap_rd,
    input  logic              ins_trap_wr,
    input  logic              fl_all,
    input  logic              fl_proc,
    input  logic              fl_page,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASN_W-1:0]  fl_asn,
    input  logic              vic_adv,
    output logic [IDX_W-1:0]  vic_ptr,
    output logic              vic_valid,
    output logic [VPN_W-1:0]  vic_vpn,
    output logic [PPN_W-1:0]  vic_ppn,
    output logic [ASN_W-1:0]  vic_asn,
    output logic              vic_global
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    typedef struct packed {
        logic [IDX_W-1:0]              ptr;
        logic [NUM_ENTRIES-1:0]        valid;
        tlb_entry_t [NUM_ENTRIES-1:0]  ent;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_ENTRIES-1:0] lk_match;
    logic [NUM_ENTRIES-1:0] fl_match;
    logic [NUM_ENTRIES-1:0] glob_vec;
    logic                   any_flush;
    logic                   ins_take;
    tlb_entry_t             new_ent;
    tlb_entry_t             hit_ent;

    // Lookup comparators and an identical bank for the single-page flush.
    tlb_cam_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_lk_cam (
        .ent_i   (st_q.ent),
        .valid_i (st_q.valid),
        .vpn_i   (lk_vpn),
        .asn_i   (lk_asn),
        .hit_o   (lk_match)
    );

    tlb_cam_match #(.NUM_ENTRIES(NUM_ENTRIES)) u_fl_cam (
        .ent_i   (st_q.ent),
        .valid_i (st_q.valid),
        .vpn_i   (fl_vpn),
        .asn_i   (fl_asn),
        .hit_o   (fl_match)
    );

    tlb_first_hit #(.NUM_ENTRIES(NUM_ENTRIES)) u_first (
        .req_i   (lk_match),
        .found_o (lk_hit),
        .idx_o   (lk_idx)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_glob
        assign glob_vec[g] = st_q.ent[g].glob;
    end

    assign hit_ent    = st_q.ent[lk_idx];
    assign lk_ppn     = lk_hit ? hit_ent.ppn : '0;
    assign lk_rd_en   = lk_hit ? hit_ent.rd_en : '0;
    assign lk_wr_en   = lk_hit ? hit_ent.wr_en : '0;
    assign lk_trap_rd = lk_hit && hit_ent.trap_rd;
    assign lk_trap_wr = lk_hit && hit_ent.trap_wr;

    assign vic_ptr    = st_q.ptr;
    assign vic_valid  = st_q.valid[st_q.ptr];
    assign vic_vpn    = st_q.ent[st_q.ptr].vpn;
    assign vic_ppn    = st_q.ent[st_q.ptr].ppn;
    assign vic_asn    = st_q.ent[st_q.ptr].asn;
    assign vic_global = st_q.ent[st_q.ptr].glob;

    assign any_flush = fl_all || fl_proc || fl_page;
    assign ins_take  = ins_valid && !any_flush;

    always_comb begin
        new_ent.vpn     = ins_vpn;
        new_ent.ppn     = ins_ppn;
        new_ent.asn     = ins_asn;
        new_ent.glob    = ins_global;
        new_ent.rd_en   = ins_rd_en;
        new_ent.wr_en   = ins_wr_en;
        new_ent.trap_rd = ins_trap_rd;
        new_ent.trap_wr = ins_trap_wr;
    end

    always_comb begin
        st_d = st_q;
        if (fl_all) begin
            st_d.valid = '0;
        end else begin
            if (fl_proc) st_d.valid = st_d.valid & glob_vec;
            if (fl_page) st_d.valid = st_d.valid & ~fl_match;
        end
        if (ins_take) begin
            st_d.ent[st_q.ptr]   = new_ent;
            st_d.valid[st_q.ptr] = 1'b1;
        end
        if (fl_all) begin
            st_d.ptr = '0;
        end else if (ins_take || vic_adv) begin
            st_d.ptr = (st_q.ptr == LAST_IDX) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: a reported hit always names a live slot
    a_r2_hit_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> st_q.valid[lk_idx]);

    // R5: the reported slot matches and no lower slot matches
    a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_match[lk_idx] &&
                    ((lk_match & ((NUM_ENTRIES'(1) << lk_idx) - 1'b1)) == '0)));

    // R4: an accepted insert at the last slot wraps the pointer to zero
    a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !any_flush && st_q.ptr == LAST_IDX) |=> (st_q.ptr == '0));

    // R6: full flush empties the buffer and rewinds the pointer
    a_r6_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        fl_all |=> (st_q.ptr == '0 && st_q.valid == '0));

    // R7: after a process flush only global slots remain
    a_r7_globals_only: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_proc && !fl_all) |=> ((st_q.valid & ~glob_vec) == '0));

    // R10: a flush drops a concurrent insert, so the pointer holds
    a_r10_insert_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && (fl_proc || fl_page) && !fl_all && !vic_adv) |=> $stable(st_q.ptr));
endmodule

// File: tb/sim_asn_tlb.sv
module sim_asn_tlb;
    import tlb_pkg::*;

    localparam int N     = 4;
    localparam int IDX_W = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [VPN_W-1:0]  lk_vpn;
    logic [ASN_W-1:0]  lk_asn;
    logic              lk_hit;
    logic [IDX_W-1:0]  lk_idx;
    logic [PPN_W-1:0]  lk_ppn;
    logic [MODE_N-1:0] lk_rd_en, lk_wr_en;
    logic              lk_trap_rd, lk_trap_wr;
    logic              ins_valid;
    logic [VPN_W-1:0]  ins_vpn;
    logic [PPN_W-1:0]  ins_ppn;
    logic [ASN_W-1:0]  ins_asn;
    logic              ins_global;
    logic [MODE_N-1:0] ins_rd_en, ins_wr_en;
    logic              ins_trap_rd, ins_trap_wr;
    logic              fl_all, fl_proc, fl_page;
    logic [VPN_W-1:0]  fl_vpn;
    logic [ASN_W-1:0]  fl_asn;
    logic              vic_adv;
    logic [IDX_W-1:0]  vic_ptr;
    logic              vic_valid;
    logic [VPN_W-1:0]  vic_vpn;
    logic [PPN_W-1:0]  vic_ppn;
    logic [ASN_W-1:0]  vic_asn;
    logic              vic_global;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    asn_tlb #(.NUM_ENTRIES(N)) u0 (.*);

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [ASN_W-1:0] asn;
        logic             hit;
        logic [IDX_W-1:0] idx;
        logic [PPN_W-1:0] ppn;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{vpn: 30'h10, asn: 8'd1, hit: 1'b1, idx: 2'd0, ppn: 28'h100},
        '{vpn: 30'h10, asn: 8'd3, hit: 1'b1, idx: 2'd2, ppn: 28'h300},
        '{vpn: 30'h10, asn: 8'd2, hit: 1'b0, idx: 2'd0, ppn: 28'h0},
        '{vpn: 30'h20, asn: 8'd7, hit: 1'b1, idx: 2'd1, ppn: 28'h200},
        '{vpn: 30'h30, asn: 8'd1, hit: 1'b0, idx: 2'd0, ppn: 28'h0},
        '{vpn: 30'h20, asn: 8'd2, hit: 1'b1, idx: 2'd1, ppn: 28'h200}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        ins_valid = 1'b0; fl_all = 1'b0; fl_proc = 1'b0; fl_page = 1'b0; vic_adv = 1'b0;
    endtask

    task automatic insert(input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a,
                          input logic g, input logic [PPN_W-1:0] p,
                          input logic [MODE_N-1:0] r, input logic [MODE_N-1:0] w,
                          input logic tr, input logic tw);
        ins_valid = 1'b1; ins_vpn = v; ins_asn = a; ins_global = g; ins_ppn = p;
        ins_rd_en = r; ins_wr_en = w; ins_trap_rd = tr; ins_trap_wr = tw;
        step();
    endtask

    task automatic look(input string req, input logic [VPN_W-1:0] v,
                        input logic [ASN_W-1:0] a, input logic h,
                        input logic [IDX_W-1:0] i, input logic [PPN_W-1:0] p);
        lk_vpn = v; lk_asn = a;
        #1;
        check(req, 64'(lk_hit), 64'(h));
        if (h) begin
            check(req, 64'(lk_idx), 64'(i));
            check(req, 64'(lk_ppn), 64'(p));
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        lk_vpn = '0; lk_asn = '0;
        ins_valid = 1'b0; ins_vpn = '0; ins_ppn = '0; ins_asn = '0; ins_global = 1'b0;
        ins_rd_en = '0; ins_wr_en = '0; ins_trap_rd = 1'b0; ins_trap_wr = 1'b0;
        fl_all = 1'b0; fl_proc = 1'b0; fl_page = 1'b0; fl_vpn = '0; fl_asn = '0;
        vic_adv = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;

        // R1: reset state
        check("R1 ptr", 64'(vic_ptr), 64'd0);
        check("R1 vic_valid", 64'(vic_valid), 64'd0);
        look("R1 lookup", 30'h0, 8'd0, 1'b0, 2'd0, 28'h0);

        // R11: lookup sees the insert only after the accepting edge
        insert(30'h10, 8'd1, 1'b0, 28'h100, 4'b0011, 4'b0001, 1'b0, 1'b1);
        look("R11 visible after edge", 30'h10, 8'd1, 1'b1, 2'd0, 28'h100);
        // R2: permission and trap fields of the hitting slot
        check("R2 rd_en", 64'(lk_rd_en), 64'h3);
        check("R2 wr_en", 64'(lk_wr_en), 64'h1);
        check("R2 trap_rd", 64'(lk_trap_rd), 64'd0);
        check("R2 trap_wr", 64'(lk_trap_wr), 64'd1);

        insert(30'h20, 8'd2, 1'b1, 28'h200, 4'b1111, 4'b0000, 1'b1, 1'b0);
        ins_valid = 1'b1; ins_vpn = 30'h10; ins_asn = 8'd3; ins_global = 1'b0;
        ins_ppn = 28'h300; ins_rd_en = 4'b0001; ins_wr_en = 4'b0001;
        ins_trap_rd = 1'b0; ins_trap_wr = 1'b0;
        look("R11 not visible before edge", 30'h10, 8'd3, 1'b0, 2'd0, 28'h0);
        step();
        insert(30'h10, 8'd1, 1'b0, 28'h400, 4'b0001, 4'b0001, 1'b0, 1'b0);

        // R4: pointer wrapped after four inserts; victim is slot 0
        check("R4 wrap ptr", 64'(vic_ptr), 64'd0);
        check("R9 vic_vpn", 64'(vic_vpn), 64'h10);
        check("R9 vic_ppn", 64'(vic_ppn), 64'h100);

        // R2 R3 R5: table walk of lookups
        for (int k = 0; k < 6; k++) begin
            look($sformatf("R2/R3/R5 vector %0d", k), VEC[k].vpn, VEC[k].asn,
                 VEC[k].hit, VEC[k].idx, VEC[k].ppn);
        end

        // R4: fifth insert replaces live slot 0; R5 now picks slot 3
        insert(30'h50, 8'd1, 1'b0, 28'h500, 4'b0001, 4'b0001, 1'b0, 1'b0);
        look("R4 replaced slot", 30'h10, 8'd1, 1'b1, 2'd3, 28'h400);
        look("R4 new slot", 30'h50, 8'd1, 1'b1, 2'd0, 28'h500);
        check("R4 ptr step", 64'(vic_ptr), 64'd1);

        // R9: advance without writing
        check("R9 vic_global", 64'(vic_global), 64'd1);
        vic_adv = 1'b1;
        step();
        check("R9 adv ptr", 64'(vic_ptr), 64'd2);
        look("R9 slot untouched", 30'h20, 8'd2, 1'b1, 2'd1, 28'h200);

        // R8 + R10: page flush with a concurrent insert
        fl_page = 1'b1; fl_vpn = 30'h10; fl_asn = 8'd3;
        ins_valid = 1'b1; ins_vpn = 30'h60; ins_asn = 8'd1; ins_ppn = 28'h600;
        step();
        check("R10 ptr held", 64'(vic_ptr), 64'd2);
        look("R10 insert dropped", 30'h60, 8'd1, 1'b0, 2'd0, 28'h0);
        look("R8 page gone", 30'h10, 8'd3, 1'b0, 2'd0, 28'h0);
        look("R8 other asn kept", 30'h10, 8'd1, 1'b1, 2'd3, 28'h400);

        // R7: process flush keeps globals only
        fl_proc = 1'b1;
        step();
        look("R7 global kept", 30'h20, 8'd7, 1'b1, 2'd1, 28'h200);
        look("R7 local gone a", 30'h50, 8'd1, 1'b0, 2'd0, 28'h0);
        look("R7 local gone b", 30'h10, 8'd1, 1'b0, 2'd0, 28'h0);

        // R6: flush all
        fl_all = 1'b1; vic_adv = 1'b1;
        step();
        check("R6 ptr zero", 64'(vic_ptr), 64'd0);
        check("R6 vic_valid", 64'(vic_valid), 64'd0);
        look("R6 global gone", 30'h20, 8'd7, 1'b0, 2'd0, 28'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule